// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Chain

This block joins a row of interrupt stages that share one request line to the CPU and one vector return path. Each stage latches a local request pulse into a pending bit. A per-stage enable bit decides whether that pending bit takes part. The shared request line is high whenever any enabled stage has a pending request.

When the CPU acknowledges, a priority signal ripples along the stages. The first stage's chain input is tied low. A stage with an active request drives its chain output high. A stage with no active request passes its chain input straight through. The one stage whose chain output is high while its chain input is low supplies its vector, and its pending bit is cleared. Position in the row is therefore the only source of priority, and stage 0 ranks highest.

The vectors sit in a small write-port memory, one entry per stage. The acknowledged vector appears on a registered output one cycle after the strobe. That output reads zero in every other cycle.

Top module: `irq_daisy_chain`

## Requirements
- R1: While `rst` is high at a clock edge, all pending bits clear. After that edge `int_req`, `vec_valid` and `vec_out` are 0.
- R2: A high `raise[i]` at a clock edge sets stage i's pending bit. After each edge, `int_req` equals the OR over all stages of (pending AND `enable` sampled at that edge).
- R3: A stage whose `enable` bit is low keeps its pending bit. It does not drive `int_req` and cannot win an acknowledge. Once re-enabled, it takes part again.
- R4: When `inta` is high at an edge, the enabled pending stage with the lowest index wins. In the next cycle, `vec_valid` is 1 and `vec_out` holds that stage's vector.
- R5: An acknowledge clears only the winning stage's pending bit. All other pending bits are unchanged.
- R6: When `inta` is high at an edge and no stage is enabled and pending, `vec_valid` and `vec_out` are 0 in the next cycle and no pending bit changes.
- R7: A high `vec_we` at an edge writes `vec_wdata` as the vector of stage `vec_sel`. An acknowledge at the same edge returns the value stored before that write.
- R8: If `raise[i]` is high at the same edge where stage i wins an acknowledge, stage i stays pending.
- R9: After an edge where `inta` is low, `vec_valid` and `vec_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise | input | N_STAGES | Per-stage request pulse; sets the pending bit |
| enable | input | N_STAGES | Per-stage participation enable |
| inta | input | 1 | CPU acknowledge strobe, one cycle per acknowledge |
| vec_we | input | 1 | Vector write strobe |
| vec_sel | input | IDX_W | Stage whose vector is written |
| vec_wdata | input | VEC_W | Vector value to write |
| int_req | output | 1 | Shared interrupt request to the CPU |
| vec_valid | output | 1 | High in the cycle after an acknowledge that found a winner |
| vec_out | output | VEC_W | Winning vector, zero when `vec_valid` is low |

## Verification
The properties assume that `enable` is steady and meaningful at each edge. They also assume that `inta` is a plain strobe that may repeat on back-to-back cycles, with no handshake to honour. The `int_req` property compares against `enable` as sampled at the previous edge, so any change of `enable` between edges is allowed. The bench drives every input at the falling edge and keeps `vec_sel` within the stage count. Its random mix draws sparse raise pulses, an enable mask that is usually full, and acknowledges about one cycle in three, so both collisions and idle acknowledges occur.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  parameter int unsigned DEF_STAGES = 8;
  parameter int unsigned DEF_VEC_W  = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_chain_stage.sv
module irq_chain_stage (
  input  logic clk,
  input  logic rst,
  input  logic raise,
  input  logic enable,
  input  logic ack,
  input  logic chain_in,
  output logic chain_out,
  output logic grant,
  output logic pend_q,
  output logic pend_d
);
  logic act;

  // active request = pending and enabled
  assign act       = pend_q & enable;
  // ripple: a requesting stage blocks everything downstream
  assign chain_out = chain_in | act;
  // respond only where the chain turns from low to high
  assign grant     = chain_out & ~chain_in;

  always_comb begin
    pend_d = pend_q;
    if (ack && grant) pend_d = 1'b0;
    if (raise)        pend_d = 1'b1;   // a new request outranks its own clear
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_onehot_enc.sv
module irq_onehot_enc #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  onehot,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int unsigned i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end
  assign any = |onehot;
endmodule

// File: rtl/irq_vec_ram.sv
module irq_vec_ram #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8,
  parameter int unsigned AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // read-first: a same-edge write is not seen by the read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata      <= mem[raddr];
  end
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
  import irq_chain_pkg::*;
#(
  parameter int unsigned N_STAGES = DEF_STAGES,
  parameter int unsigned VEC_W    = DEF_VEC_W,
  parameter int unsigned IDX_W    = idx_width(N_STAGES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_STAGES-1:0] raise,
  input  logic [N_STAGES-1:0] enable,
  input  logic                inta,
  input  logic                vec_we,
  input  logic [IDX_W-1:0]    vec_sel,
  input  logic [VEC_W-1:0]    vec_wdata,
  output logic                int_req,
  output logic                vec_valid,
  output logic [VEC_W-1:0]    vec_out
);
  localparam int unsigned CHAIN_LEN = N_STAGES + 1;

  logic [CHAIN_LEN-1:0] chain;
  logic [N_STAGES-1:0]  grant_vec;
  logic [N_STAGES-1:0]  pend_vec;
  logic [N_STAGES-1:0]  pend_nxt;
  logic [IDX_W-1:0]     win_idx;
  logic                 win_any;
  logic [VEC_W-1:0]     ram_q;
  logic                 int_req_q;
  logic                 valid_q;
  logic                 wr_ok;

  // head of the chain is tied low: stage 0 ranks highest
  assign chain[0] = 1'b0;

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    irq_chain_stage u_stage (
      .clk       (clk),
      .rst       (rst),
      .raise     (raise[g]),
      .enable    (enable[g]),
      .ack       (inta),
      .chain_in  (chain[g]),
      .chain_out (chain[g+1]),
      .grant     (grant_vec[g]),
      .pend_q    (pend_vec[g]),
      .pend_d    (pend_nxt[g])
    );
  end

  irq_onehot_enc #(.N(N_STAGES), .IW(IDX_W)) u_enc (
    .onehot (grant_vec),
    .idx    (win_idx),
    .any    (win_any)
  );

  assign wr_ok = vec_we && (32'(vec_sel) < N_STAGES);

  irq_vec_ram #(.DEPTH(N_STAGES), .W(VEC_W), .AW(IDX_W)) u_ram (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (vec_sel),
    .wdata (vec_wdata),
    .re    (inta && win_any),
    .raddr (win_idx),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_req_q <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      int_req_q <= |(pend_nxt & enable);
      valid_q   <= inta && win_any;
    end
  end

  assign int_req   = int_req_q;
  assign vec_valid = valid_q;
  assign vec_out   = valid_q ? ram_q : '0;
endmodule

// File: rtl/irq_daisy_chain_chk.sv
module irq_daisy_chain_chk #(
  parameter int unsigned N_STAGES = 8,
  parameter int unsigned VEC_W    = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [N_STAGES-1:0] raise,
  input logic [N_STAGES-1:0] enable,
  input logic                inta,
  input logic                int_req,
  input logic                vec_valid,
  input logic [VEC_W-1:0]    vec_out,
  input logic [N_STAGES-1:0] grant_vec,
  input logic [N_STAGES-1:0] pend_vec
);
  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  AST_ONE_RESPONDER: assert property (@(posedge clk) disable iff (rst) $onehot0(grant_vec)); // R4
  AST_VALID_TRACKS_ACK: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (vec_valid == $past(inta && (|grant_vec)))); // R4
  AST_NO_ACK_QUIET: assert property (@(posedge clk) disable iff (rst) !inta |=> (!vec_valid && vec_out == '0)); // R9
  AST_EMPTY_ACK_QUIET: assert property (@(posedge clk) disable iff (rst) (inta && grant_vec == '0) |=> (vec_out == '0 && !vec_valid)); // R6
  AST_WINNER_CLEARED: assert property (@(posedge clk) disable iff (rst) inta |=> ((pend_vec & $past(grant_vec & ~raise)) == '0)); // R5
  AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (rst) inta |=> ((pend_vec & $past(pend_vec & ~grant_vec)) == $past(pend_vec & ~grant_vec))); // R5
  AST_RAISE_WINS: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> ((pend_vec & $past(raise)) == $past(raise))); // R8
  AST_REQ_LINE: assert property (@(posedge clk) disable iff (rst) live |-> (int_req == |(pend_vec & $past(enable)))); // R2
endmodule

bind irq_daisy_chain irq_daisy_chain_chk #(.N_STAGES(N_STAGES), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .raise     (raise),
  .enable    (enable),
  .inta      (inta),
  .int_req   (int_req),
  .vec_valid (vec_valid),
  .vec_out   (vec_out),
  .grant_vec (grant_vec),
  .pend_vec  (pend_vec)
);

// File: tb/irq_daisy_chain_tb.sv
module irq_daisy_chain_tb;
  localparam int N  = 8;
  localparam int VW = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  raise;
  logic [N-1:0]  enable;
  logic          inta;
  logic          vec_we;
  logic [IW-1:0] vec_sel;
  logic [VW-1:0] vec_wdata;
  logic          int_req;
  logic          vec_valid;
  logic [VW-1:0] vec_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [N-1:0]  pend_m;
  logic [VW-1:0] vec_m [N];

  always #5 clk = ~clk;

  irq_daisy_chain #(.N_STAGES(N), .VEC_W(VW)) u_dut (
    .clk(clk), .rst(rst), .raise(raise), .enable(enable), .inta(inta),
    .vec_we(vec_we), .vec_sel(vec_sel), .vec_wdata(vec_wdata),
    .int_req(int_req), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  function automatic int winner(input logic [N-1:0] p, input logic [N-1:0] e);
    for (int i = 0; i < N; i++) if (p[i] && e[i]) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // drive at falling edge, model the rising edge, check at next falling edge
  task automatic step(input logic [N-1:0] r, input logic [N-1:0] e, input bit a,
                      input bit we, input int sel, input logic [VW-1:0] wd, input string tag);
    int w;
    bit exp_v;
    logic [VW-1:0] exp_vec;
    bit exp_req;
    raise = r; enable = e; inta = a; vec_we = we; vec_sel = IW'(sel); vec_wdata = wd;
    @(posedge clk);
    w = winner(pend_m, e);
    exp_v   = a && (w >= 0);
    exp_vec = exp_v ? vec_m[w] : '0;
    if (we) vec_m[sel] = wd;
    if (exp_v) pend_m[w] = 1'b0;
    pend_m  = pend_m | r;
    exp_req = |(pend_m & e);
    @(negedge clk);
    chk(int_req === exp_req, tag, "int_req", int'(int_req), int'(exp_req));
    chk(vec_valid === exp_v, tag, "vec_valid", int'(vec_valid), int'(exp_v));
    chk(vec_out === exp_vec, tag, "vec_out", int'(vec_out), int'(exp_vec));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] all;
    all = '1;
    void'($urandom(32'h5A17));
    rst = 1'b1; raise = '0; enable = '0; inta = 0; vec_we = 0; vec_sel = '0; vec_wdata = '0;
    pend_m = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(int_req === 1'b0, "R1", "int_req", int'(int_req), 0);
    chk(vec_valid === 1'b0, "R1", "vec_valid", int'(vec_valid), 0);
    chk(vec_out === '0, "R1", "vec_out", int'(vec_out), 0);
    rst = 1'b0;

    // R7: load distinct vectors
    for (int i = 0; i < N; i++) step('0, all, 0, 1, i, VW'(8'h40 + i * 3), "R7");

    // R2: raise sets request line
    step(8'b0010_0100, all, 0, 0, 0, '0, "R2");
    // R4: lowest index wins (stage 2 before 5)
    step('0, all, 1, 0, 0, '0, "R4");
    // R5: stage 5 still pending, now wins
    step('0, all, 1, 0, 0, '0, "R5");
    // R6: acknowledge with nothing pending
    step('0, all, 1, 0, 0, '0, "R6");
    // R9: idle cycle after acknowledge
    step('0, all, 0, 0, 0, '0, "R9");

    // R3: stage 1 disabled but pending, stage 6 enabled
    step(8'b0100_0010, 8'b1111_1101, 0, 0, 0, '0, "R3");
    step('0, 8'b1111_1101, 1, 0, 0, '0, "R3");
    step('0, 8'b0000_0000, 0, 0, 0, '0, "R3");
    step('0, all, 0, 0, 0, '0, "R3");
    step('0, all, 1, 0, 0, '0, "R3");

    // R7: write and acknowledge same stage at one edge returns old value
    step(8'b0000_1000, all, 0, 0, 0, '0, "R7");
    step('0, all, 1, 1, 3, 8'hC3, "R7");
    step(8'b0000_1000, all, 1, 0, 0, '0, "R7");

    // R8: raise at the edge the same stage is acknowledged
    step(8'b0000_0001, all, 0, 0, 0, '0, "R8");
    step(8'b0000_0001, all, 1, 0, 0, '0, "R8");
    step('0, all, 1, 0, 0, '0, "R8");

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] r, e;
      r = '0;
      for (int i = 0; i < N; i++) if (($urandom % 8) == 0) r[i] = 1'b1;
      e = (($urandom % 4) == 0) ? N'($urandom) : all;
      step(r, e, ($urandom % 3) == 0, ($urandom % 10) == 0, int'($urandom % N), VW'($urandom), "R4");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule